// File: doc/BRIEF.md
# Three-Cycle Data-Break Disk Transfer Engine

This block moves 18-bit words between a head-per-track disk word store and main memory. It uses no internal count or address register for the memory side. The word count and the current memory address are kept in two fixed main-memory locations, 30 and 31 (036 and 037 octal). For every word, the engine reads each of them, adds one and writes it back. It then moves one data word at the freshly incremented address. The disk address is held inside the engine and steps by one after each word that is moved.

The transfer is launched by a start pulse that carries a function code, a starting disk address and a burst flag. The function can read the disk into memory, write memory to the disk, or compare memory against the disk without changing either. In burst mode the words follow one another with no gaps. Otherwise each word waits for a grant pulse from the rotational timing logic. The transfer stops when the incremented count wraps to zero, or at the first error. The errors are a verify mismatch, a write to a protected track group, or a disk address at or beyond the configured capacity. The done flag then rises.

Top module: `dbreak_xfer`

## Requirements
- R1: After reset, busy, done, all three error flags, memReq and dskWe are low.
- R2: Each word first reads location 30, writes it back plus one (mod 2^18), reads location 31, writes it back plus one. The data word then uses the incremented value of location 31 as its memory address.
- R3: A transfer ends after the word whose incremented count is zero, so a length N is loaded as -N. Location 30 then holds 0, busy falls and done rises; done and busy are never high together.
- R4: Function code 1 copies disk[d] into memory at the word's address, and the disk address advances by one per word.
- R5: Function code 2 copies the memory word at the word's address into disk[d].
- R6: Function code 3 changes neither memory nor disk. On the first mismatch it sets errVerify, sets done and stops, leaving the disk address on the failing word.
- R7: For writes, lockMask bit index {d[20:18], d[17:14]} (disk*16 + group) protects that region. A write into a protected region raises errLock, leaves the disk word unchanged and stops. Unprotected regions are written.
- R8: If the disk address is at or above capWords when a word is due, errNoDisk and done are set. The transfer stops before that word's count and address are touched.
- R9: With burstMode low, no word begins until a wordGrant pulse; without grants location 30 stays unchanged. With burstMode high, words run back to back.
- R10: A start with function code 0, or any start while busy, is ignored.
- R11: A read whose target address is not below memSize writes nothing to memory, but the count, address and disk address still advance.
- R12: A memory request holds memReq, memWe and memAddr stable until memRdy.
- R13: A new accepted start clears done and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| startFn | input | 2 | Function: 0 none, 1 disk to memory, 2 memory to disk, 3 verify |
| startDiskAddr | input | 21 | First disk word address |
| burstMode | input | 1 | 1: words back to back; 0: one word per grant |
| wordGrant | input | 1 | Interword slot pulse |
| lockMask | input | 128 | Protection bit per disk and track group |
| capWords | input | 22 | Installed disk capacity in words |
| memSize | input | 19 | Installed memory size in words |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write when 1, read when 0 |
| memAddr | output | 18 | Memory address |
| memWdata | output | 18 | Memory write data |
| memRdy | input | 1 | Memory accepts request; read data valid |
| memRdata | input | 18 | Memory read data |
| dskAddr | output | 21 | Disk word address (current disk address) |
| dskWe | output | 1 | Disk word write strobe |
| dskWdata | output | 18 | Disk write data |
| dskRdata | input | 18 | Disk word at dskAddr (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| errVerify | output | 1 | Verify mismatch |
| errLock | output | 1 | Write to protected region |
| errNoDisk | output | 1 | Disk address beyond capacity |

## Verification
The bench tries each function in turn: reads in burst, writes with grant pulses, and verifies that match throughout or fail on their second word. Comparing locations 30 and 31 and the final disk address after each run shows whether the engine stopped at the right word. It also shows whether a word was counted before the engine stopped. Edge patterns cover these cases:
- a protected group next to an unprotected one, which shows the lock index decoding;
- a run that crosses the capacity limit;
- a run that crosses the top of installed memory;
- a one-word run whose address wraps from 2^18-1 to 0.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  typedef enum logic [1:0] {
    FN_IDLE    = 2'd0,
    FN_DSK2MEM = 2'd1,
    FN_MEM2DSK = 2'd2,
    FN_VERIFY  = 2'd3
  } xferFn_t;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_WORD  = 2'd2
  } memSel_t;

  typedef struct packed {
    logic    loadStart;
    logic    takeCount;
    logic    takeAddr;
    logic    stepDisk;
    memSel_t memSel;
  } dpStrobe_t;
endpackage

// File: rtl/dbx_data.sv
module dbx_data
  import dbx_pkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int DA_W       = 21,
  parameter int DISK_BITS  = 3,
  parameter int GROUP_BITS = 4,
  parameter int COUNT_LOC  = 30,
  parameter int ADDR_LOC   = 31,
  localparam int IDX_W     = DISK_BITS + GROUP_BITS,
  localparam int LOCK_W    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DA_W-1:0]   startDa,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] dskRdata,
  input  logic [LOCK_W-1:0] lockMask,
  input  logic [DA_W:0]     capWords,
  input  logic [WORD_W:0]   memSize,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [DA_W-1:0]   dskAddr,
  output logic [WORD_W-1:0] dskWdata,
  output logic              countZero,
  output logic              diskOver,
  output logic              regionLocked,
  output logic              verifyMiss,
  output logic              targetInMem
);
  localparam logic [WORD_W-1:0] CNT_A = WORD_W'(COUNT_LOC);
  localparam logic [WORD_W-1:0] ADR_A = WORD_W'(ADDR_LOC);

  logic [WORD_W-1:0] countReg;
  logic [WORD_W-1:0] addrReg;
  logic [DA_W-1:0]   daReg;
  logic [IDX_W-1:0]  lockIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      addrReg  <= '0;
      daReg    <= '0;
    end else begin
      if (strobe.loadStart) daReg <= startDa;
      if (strobe.takeCount) countReg <= memRdata + 1'b1;
      if (strobe.takeAddr)  addrReg  <= memRdata + 1'b1;
      if (strobe.stepDisk)  daReg    <= daReg + 1'b1;
    end
  end

  // disk number and track group sit side by side at the top of the address
  assign lockIdx      = daReg[DA_W-1 -: IDX_W];
  assign regionLocked = lockMask[lockIdx];
  assign countZero    = (countReg == '0);
  assign diskOver     = ({1'b0, daReg} >= capWords);
  assign verifyMiss   = (memRdata != dskRdata);
  assign targetInMem  = ({1'b0, addrReg} < memSize);

  always_comb begin
    unique case (strobe.memSel)
      SEL_COUNT: begin memAddr = CNT_A;   memWdata = countReg; end
      SEL_ADDR:  begin memAddr = ADR_A;   memWdata = addrReg;  end
      default:   begin memAddr = addrReg; memWdata = dskRdata; end
    endcase
  end

  assign dskAddr  = daReg;
  assign dskWdata = memRdata;
endmodule

// File: rtl/dbx_ctrl.sv
module dbx_ctrl
  import dbx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  xferFn_t   startFn,
  input  logic      burst,
  input  logic      wordGrant,
  input  logic      memRdy,
  input  logic      countZero,
  input  logic      diskOver,
  input  logic      regionLocked,
  input  logic      verifyMiss,
  input  logic      targetInMem,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      dskWe,
  output logic      busy,
  output logic      done,
  output logic      errVerify,
  output logic      errLock,
  output logic      errNoDisk
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CNT_RD, ST_CNT_WR, ST_ADR_RD, ST_ADR_WR, ST_WORD
  } state_t;

  state_t  state, nextState;
  xferFn_t fnReg;
  logic    burstReg;
  logic    finish, wordEnd, setV, setL, setN;

  always_comb begin
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    dskWe     = 1'b0;
    finish    = 1'b0;
    wordEnd   = 1'b0;
    setV      = 1'b0;
    setL      = 1'b0;
    setN      = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start && startFn != FN_IDLE) begin
        strobe.loadStart = 1'b1;
        nextState        = ST_WAIT;
      end
      ST_WAIT: if (burstReg || wordGrant) begin
        if (diskOver) begin
          setN   = 1'b1;
          finish = 1'b1;
        end else nextState = ST_CNT_RD;
      end
      ST_CNT_RD: begin
        memReq = 1'b1;
        strobe.memSel = SEL_COUNT;
        if (memRdy) begin
          strobe.takeCount = 1'b1;
          nextState        = ST_CNT_WR;
        end
      end
      ST_CNT_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.memSel = SEL_COUNT;
        if (memRdy) nextState = ST_ADR_RD;
      end
      ST_ADR_RD: begin
        memReq = 1'b1;
        strobe.memSel = SEL_ADDR;
        if (memRdy) begin
          strobe.takeAddr = 1'b1;
          nextState       = ST_ADR_WR;
        end
      end
      ST_ADR_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.memSel = SEL_ADDR;
        if (memRdy) nextState = ST_WORD;
      end
      ST_WORD: begin
        strobe.memSel = SEL_WORD;
        unique case (fnReg)
          FN_DSK2MEM: begin
            if (targetInMem) begin
              memReq = 1'b1;
              memWe  = 1'b1;
              wordEnd = memRdy;
            end else wordEnd = 1'b1;
          end
          FN_MEM2DSK: begin
            memReq = 1'b1;
            if (memRdy) begin
              if (regionLocked) begin
                setL   = 1'b1;
                finish = 1'b1;
              end else begin
                dskWe   = 1'b1;
                wordEnd = 1'b1;
              end
            end
          end
          FN_VERIFY: begin
            memReq = 1'b1;
            if (memRdy) begin
              if (verifyMiss) begin
                setV   = 1'b1;
                finish = 1'b1;
              end else wordEnd = 1'b1;
            end
          end
          default: finish = 1'b1;
        endcase
        if (wordEnd) begin
          strobe.stepDisk = 1'b1;
          if (countZero) finish = 1'b1;
          else nextState = ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (finish) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fnReg     <= FN_IDLE;
      burstReg  <= 1'b0;
      done      <= 1'b0;
      errVerify <= 1'b0;
      errLock   <= 1'b0;
      errNoDisk <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadStart) begin
        fnReg     <= startFn;
        burstReg  <= burst;
        done      <= 1'b0;
        errVerify <= 1'b0;
        errLock   <= 1'b0;
        errNoDisk <= 1'b0;
      end
      if (finish) done <= 1'b1;
      if (setV) errVerify <= 1'b1;
      if (setL) errLock   <= 1'b1;
      if (setN) errNoDisk <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/dbreak_xfer.sv
module dbreak_xfer
  import dbx_pkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int DA_W       = 21,
  parameter int DISK_BITS  = 3,
  parameter int GROUP_BITS = 4,
  parameter int COUNT_LOC  = 30,
  parameter int ADDR_LOC   = 31,
  localparam int LOCK_W    = 1 << (DISK_BITS + GROUP_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        startFn,
  input  logic [DA_W-1:0]   startDiskAddr,
  input  logic              burstMode,
  input  logic              wordGrant,
  input  logic [LOCK_W-1:0] lockMask,
  input  logic [DA_W:0]     capWords,
  input  logic [WORD_W:0]   memSize,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memRdy,
  input  logic [WORD_W-1:0] memRdata,
  output logic [DA_W-1:0]   dskAddr,
  output logic              dskWe,
  output logic [WORD_W-1:0] dskWdata,
  input  logic [WORD_W-1:0] dskRdata,
  output logic              busy,
  output logic              done,
  output logic              errVerify,
  output logic              errLock,
  output logic              errNoDisk
);
  dpStrobe_t strobe;
  logic countZero, diskOver, regionLocked, verifyMiss, targetInMem;

  dbx_ctrl u_ctrl (
    .clk, .rstN, .start,
    .startFn(xferFn_t'(startFn)),
    .burst(burstMode), .wordGrant, .memRdy,
    .countZero, .diskOver, .regionLocked, .verifyMiss, .targetInMem,
    .strobe, .memReq, .memWe, .dskWe, .busy, .done,
    .errVerify, .errLock, .errNoDisk
  );

  dbx_data #(
    .WORD_W(WORD_W), .DA_W(DA_W), .DISK_BITS(DISK_BITS),
    .GROUP_BITS(GROUP_BITS), .COUNT_LOC(COUNT_LOC), .ADDR_LOC(ADDR_LOC)
  ) u_data (
    .clk, .rstN, .strobe,
    .startDa(startDiskAddr), .memRdata, .dskRdata, .lockMask,
    .capWords, .memSize, .memAddr, .memWdata, .dskAddr, .dskWdata,
    .countZero, .diskOver, .regionLocked, .verifyMiss, .targetInMem
  );
endmodule

// File: rtl/dbx_checker.sv
module dbx_checker #(
  parameter int WORD_W = 18,
  parameter int DA_W   = 21,
  parameter int IDX_W  = 7,
  localparam int LOCK_W = 1 << IDX_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [WORD_W-1:0] memAddr,
  input logic              memRdy,
  input logic              dskWe,
  input logic [DA_W-1:0]   dskAddr,
  input logic [LOCK_W-1:0] lockMask,
  input logic              busy,
  input logic              done,
  input logic              errVerify,
  input logic              errLock,
  input logic              errNoDisk
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdy |=> memReq && $stable(memAddr) && $stable(memWe));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R5
  dsk_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dskWe |-> busy && memRdy && memReq && !memWe);

  // R7
  lock_respect_chk: assert property (@(posedge clk) disable iff (!rstN)
    dskWe |-> !lockMask[dskAddr[DA_W-1 -: IDX_W]]);

  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errVerify || errLock || errNoDisk) && !busy |-> done);

  // R3
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind dbreak_xfer dbx_checker #(
  .WORD_W(WORD_W), .DA_W(DA_W), .IDX_W(DISK_BITS + GROUP_BITS)
) u_chk (
  .clk, .rstN, .memReq, .memWe, .memAddr, .memRdy, .dskWe, .dskAddr,
  .lockMask, .busy, .done, .errVerify, .errLock, .errNoDisk
);

// File: tb/sim_dbreak_xfer.sv
`timescale 1ns/1ps
module sim_dbreak_xfer;
  localparam int WW = 18;
  localparam int DW = 21;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    startFn = '0;
  logic [DW-1:0] startDiskAddr = '0;
  logic          burstMode = 1'b0;
  logic          wordGrant = 1'b0;
  logic [127:0]  lockMask = '0;
  logic [DW:0]   capWords = 22'd2097152;
  logic [WW:0]   memSize = 19'd256;
  logic          memReq, memWe, memRdy;
  logic [WW-1:0] memAddr, memWdata, memRdata;
  logic [DW-1:0] dskAddr;
  logic          dskWe;
  logic [WW-1:0] dskWdata, dskRdata;
  logic          busy, done, errVerify, errLock, errNoDisk;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [WW-1:0] mem [256];
  logic [WW-1:0] dskStore [int];
  logic          tbWrEn = 1'b0;
  logic [7:0]    tbWrAddr = '0;
  logic [WW-1:0] tbWrData = '0;

  always #2 clk = ~clk;

  dbreak_xfer u0 (.*);

  function automatic logic [WW-1:0] pat(input int a);
    return WW'(a * 37 + 5);
  endfunction

  function automatic logic [WW-1:0] diskWord(input logic [DW-1:0] a);
    if (dskStore.exists(int'(a))) return dskStore[int'(a)];
    return pat(int'(a));
  endfunction

  assign dskRdata = diskWord(dskAddr);

  always @(posedge clk) begin
    if (!rstN) memRdy <= 1'b0;
    else begin
      memRdy <= memReq && !memRdy;
      if (memReq && !memRdy) memRdata <= mem[memAddr[7:0]];
      if (memReq && memRdy && memWe) mem[memAddr[7:0]] <= memWdata;
    end
    if (tbWrEn) mem[tbWrAddr] <= tbWrData;
    if (dskWe) dskStore[int'(dskAddr)] = dskWdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [WW-1:0] d);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrAddr = 8'(a); tbWrData = d;
    @(negedge clk);
    tbWrEn = 1'b0;
  endtask

  task automatic setup(input int n, input int ca);
    poke(30, WW'(-n));
    poke(31, WW'(ca));
  endtask

  task automatic launch(input logic [1:0] fn, input int da, input logic bst);
    @(negedge clk);
    start = 1'b1; startFn = fn; startDiskAddr = DW'(da); burstMode = bst;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishRun(input logic grants);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!busy) break;
      wordGrant = grants && (i % 4 == 0);
    end
    wordGrant = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 flags", {done, errVerify, errLock, errNoDisk}, 0);
    chk("R1 strobes", {memReq, dskWe}, 0);

    // R4 R2 burst read of 4 words
    setup(4, 'h40);
    launch(2'd1, 5, 1'b1);
    finishRun(1'b0);
    for (int i = 0; i < 4; i++) chk("R4 read word", mem['h41 + i], pat(5 + i));
    chk("R3 count zero", mem[30], 0);
    chk("R2 addr loc", mem[31], 'h44);
    chk("R4 disk addr", dskAddr, 9);
    chk("R3 done", {done, busy}, 2'b10);

    // R9 R5 R10 write with grants, start while busy ignored
    for (int i = 0; i < 3; i++) poke('h61 + i, WW'('h1100 + i));
    setup(3, 'h60);
    launch(2'd2, 100, 1'b0);
    repeat (20) @(negedge clk);
    chk("R9 no grant count", mem[30], 'h3FFFD);
    chk("R9 still busy", busy, 1);
    launch(2'd1, 7, 1'b1);
    finishRun(1'b1);
    for (int i = 0; i < 3; i++) chk("R5 disk word", diskWord(DW'(100 + i)), 'h1100 + i);
    chk("R10 busy start ignored", dskAddr, 103);
    chk("R3 count zero write", mem[30], 0);

    // R6 verify match
    poke('h81, pat(200)); poke('h82, pat(201));
    setup(2, 'h80);
    launch(2'd3, 200, 1'b1);
    finishRun(1'b0);
    chk("R6 no error", {done, errVerify}, 2'b10);
    chk("R6 mem unchanged", mem['h82], pat(201));
    chk("R6 disk addr", dskAddr, 202);

    // R6 verify mismatch on second word
    poke('h91, pat(300)); poke('h92, pat(301) ^ 18'd1); poke('h93, pat(302));
    setup(3, 'h90);
    launch(2'd3, 300, 1'b1);
    finishRun(1'b0);
    chk("R6 mismatch flag", {done, errVerify}, 2'b11);
    chk("R6 count at stop", mem[30], 'h3FFFF);
    chk("R6 addr at stop", mem[31], 'h92);
    chk("R6 disk addr held", dskAddr, 301);
    chk("R6 disk unchanged", diskWord(DW'(301)), pat(301));

    // R7 R13 locked group: disk 1 group 3 is bit 19
    lockMask = '0; lockMask[19] = 1'b1;
    poke('hA1, 'h2222);
    setup(2, 'hA0);
    launch(2'd2, 'h4C000, 1'b1);
    finishRun(1'b0);
    chk("R13 verify err cleared", errVerify, 0);
    chk("R7 lock flag", {done, errLock}, 2'b11);
    chk("R7 word not written", diskWord(DW'('h4C000)), pat('h4C000));
    chk("R7 count at stop", mem[30], 'h3FFFF);
    chk("R7 disk addr held", dskAddr, 'h4C000);
    poke('hB1, 'h3333);
    setup(1, 'hB0);
    launch(2'd2, 'h48000, 1'b1);
    finishRun(1'b0);
    chk("R7 neighbour written", diskWord(DW'('h48000)), 'h3333);
    chk("R13 lock cleared", errLock, 0);

    // R8 capacity limit
    capWords = 22'd1000;
    setup(5, 'hC0);
    launch(2'd1, 998, 1'b1);
    finishRun(1'b0);
    chk("R8 nxd flag", {done, errNoDisk}, 2'b11);
    chk("R8 words before limit", mem['hC2], pat(999));
    chk("R8 count untouched", mem[30], 'h3FFFD);
    chk("R8 addr untouched", mem[31], 'hC2);
    capWords = 22'd2097152;

    // R11 reads beyond installed memory
    poke('hD2, 'h3ABCD); poke('hD3, 'h3ABCD);
    memSize = 19'hD2;
    setup(3, 'hD0);
    launch(2'd1, 400, 1'b1);
    finishRun(1'b0);
    chk("R11 in range word", mem['hD1], pat(400));
    chk("R11 dropped word", mem['hD2], 'h3ABCD);
    chk("R11 dropped word2", mem['hD3], 'h3ABCD);
    chk("R11 counters advance", {mem[30], mem[31]}, {18'd0, 18'hD3});
    chk("R11 disk addr", dskAddr, 403);
    memSize = 19'd256;

    // R10 function zero ignored
    poke(30, 'h12345);
    launch(2'd0, 600, 1'b1);
    chk("R10 nop not busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R10 nop count kept", mem[30], 'h12345);
    chk("R10 nop disk addr", dskAddr, 403);

    // R2 R3 single word with address wrap
    setup(1, 'h3FFFF);
    launch(2'd1, 500, 1'b1);
    finishRun(1'b0);
    chk("R2 wrapped target", mem[0], pat(500));
    chk("R2 addr wrap", mem[31], 0);
    chk("R3 single word end", {mem[30], 14'(done)}, {18'd0, 14'd1});

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule